// File: doc/BRIEF.md
# MDIO Management Target

This block sits on the PHY side of a two-wire management bus and answers the station manager. It samples the bus clock and the shared data line in its own system clock domain. It finds a preamble of ones and the start field that follows it, then decodes the operation, the device address and the register address of each frame. Write frames aimed at this device store their 16-bit payload in an internal bank of 32 registers. Read frames aimed at this device make the block take the data line through an output enable, drive the second turnaround bit low and then shift the addressed register out.

The device address to answer is supplied on a 5-bit input. This is typically tied to board straps. The block changes the value it drives only just after it sees a falling edge of the bus clock. Each driven bit is therefore stable for the whole high phase, which is when the manager samples it. Any frame that breaks the expected framing is dropped, and the block then waits for a fresh preamble.

Top module: `mdio_target`

## Requirements
- R1: After reset the output enable is low and all 32 registers hold zero.
- R2: A write is accepted and stored when its frame has at least 32 ones, start field 0 then 1, opcode 0 then 1, a matching 5-bit device address, a 5-bit register address, turnaround 1 then 0, and 16 data bits, with every field sent most significant bit first. A later read frame (opcode 1 then 0) to the same register returns that data.
- R3: On a matching read, the first turnaround bit is left undriven and the second is driven 0. The 16 register bits follow, most significant first. The output enable is low again after the falling clock edge that follows the last data bit, and it stays low throughout any write frame.
- R4: The driven value and the output enable change only within 4 system clocks after a falling edge of the bus clock reaches the input pin.
- R5: A frame whose device address differs from the configured address leaves the output enable low for the whole frame, and a write in such a frame is not stored.
- R6: A frame whose start field follows fewer than 32 consecutive ones is ignored: a read gets no drive and a write is not stored.
- R7: A start field other than 0 then 1 aborts the frame with no store. The next frame that has a full preamble is accepted.
- R8: A write whose turnaround is not 1 then 0 aborts the frame and stores nothing.
- R9: The opcodes 0,0 and 1,1 abort the frame: nothing is driven and nothing is stored.
- R10: The 32 registers are independent, including the addresses 0 and 31.
- R11: A preamble longer than 32 ones is accepted like one of exactly 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr_cfg | input | 5 | Device address this target answers to |
| mdc_in | input | 1 | Bus clock from the station manager |
| mdio_in | input | 1 | Resolved level of the shared data line |
| mdio_out | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | High while the target drives the data line |

## Verification
A wrong parse state is visible at the pins within one frame. Examples are a field counter off by one, a preamble count that is not cleared, or a stale address-match flag. Any of these shifts the read data by a bit, takes the line during a frame for another device or during a write, or lets a write land in the bank. The write case shows up on the next read-back. A drive register that updates on the wrong clock edge shows up inside the same bit time, as an output change more than four system clocks after a bus-clock fall. A corrupted register row appears on the first read of that address.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

    localparam int PRE_LEN = 32;
    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_CW  = $clog2(PRE_LEN + 1);
    localparam int FLD_CW  = $clog2(DATA_W);

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;
    localparam logic [1:0] TA_WR  = 2'b10;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } fsm_e;

    typedef enum logic [1:0] {
        XACT_NONE,
        XACT_RD,
        XACT_WR
    } xact_e;

    typedef struct packed {
        logic oe;
        logic dat;
    } pin_drv_t;

    typedef struct packed {
        logic [REG_AW-1:0] regad;
        xact_e             kind;
        logic              hit;
    } hdr_t;

    function automatic xact_e decode_op(input logic [1:0] op);
        case (op)
            OPC_RD:  return XACT_RD;
            OPC_WR:  return XACT_WR;
            default: return XACT_NONE;
        endcase
    endfunction

    function automatic logic [FLD_CW-1:0] field_last(input fsm_e s);
        case (s)
            ST_OP:   return FLD_CW'(1);
            ST_PHY:  return FLD_CW'(PHY_AW - 1);
            ST_REG:  return FLD_CW'(REG_AW - 1);
            ST_TA:   return FLD_CW'(1);
            ST_DATA: return FLD_CW'(DATA_W - 1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_in,
    input  logic mdio_in,
    output logic rise_evt,
    output logic fall_evt,
    output logic bit_s
);
    logic [STAGES-1:0] mdc_ff;
    logic [STAGES-1:0] dat_ff;
    logic              mdc_prev;
    logic              mdc_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_ff[g] <= 1'b0;
                    dat_ff[g] <= 1'b1;
                end else begin
                    mdc_ff[g] <= mdc_in;
                    dat_ff[g] <= mdio_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    mdc_ff[g] <= 1'b0;
                    dat_ff[g] <= 1'b1;
                end else begin
                    mdc_ff[g] <= mdc_ff[g-1];
                    dat_ff[g] <= dat_ff[g-1];
                end
            end
        end
    end

    assign mdc_s = mdc_ff[STAGES-1];
    assign bit_s = dat_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b0;
        else     mdc_prev <= mdc_s;
    end

    assign rise_evt = mdc_s & ~mdc_prev;
    assign fall_evt = ~mdc_s & mdc_prev;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int NROW = 1 << AW;

    logic [DW-1:0]   rows [NROW];
    logic [NROW-1:0] row_we;

    for (genvar g = 0; g < NROW; g++) begin : g_row
        assign row_we[g] = wr_en && (addr == AW'(g));
        always_ff @(posedge clk) begin
            if (rst)            rows[g] <= '0;
            else if (row_we[g]) rows[g] <= wr_data;
        end
    end

    assign rd_data = rows[addr];

    // R10: a store touches at most one row
    assert_single_row_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_we));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              bit_s,
    input  logic [PHY_AW-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam logic [FLD_CW-1:0] TOP_IDX = FLD_CW'(DATA_W - 1);

    fsm_e              st_q;
    logic [PRE_CW-1:0] ones_q;
    logic [FLD_CW-1:0] fcnt_q;
    logic [DATA_W-1:0] sh_q;
    hdr_t              hdr_q;
    pin_drv_t          drv_q;
    pin_drv_t          drv_d;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;

    logic              fld_end;
    logic [DATA_W-1:0] sh_nx;
    logic              rd_hit;
    logic              pre_full;
    logic              ta_exp;
    xact_e             op_kind;

    assign fld_end  = (fcnt_q == field_last(st_q));
    assign sh_nx    = {sh_q[DATA_W-2:0], bit_s};
    assign rd_hit   = hdr_q.hit && (hdr_q.kind == XACT_RD);
    assign pre_full = (ones_q == PRE_CW'(PRE_LEN));
    assign ta_exp   = (fcnt_q == '0) ? TA_WR[1] : TA_WR[0];
    assign op_kind  = decode_op(sh_nx[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_HUNT;
            ones_q    <= '0;
            fcnt_q    <= '0;
            sh_q      <= '0;
            hdr_q     <= '{regad: '0, kind: XACT_NONE, hit: 1'b0};
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (rise_evt) begin
                if (st_q != ST_HUNT) begin
                    sh_q   <= sh_nx;
                    fcnt_q <= fld_end ? '0 : fcnt_q + 1'b1;
                end
                unique case (st_q)
                    ST_HUNT: begin
                        if (bit_s)         ones_q <= pre_full ? ones_q : ones_q + 1'b1;
                        else if (pre_full) st_q   <= ST_START;
                        else               ones_q <= '0;
                    end
                    ST_START: begin
                        if (bit_s) begin
                            st_q <= ST_OP;
                        end else begin
                            st_q   <= ST_HUNT;
                            ones_q <= '0;
                            fcnt_q <= '0;
                        end
                    end
                    ST_OP: begin
                        if (fld_end) begin
                            hdr_q.kind <= op_kind;
                            if (op_kind == XACT_NONE) begin
                                st_q   <= ST_HUNT;
                                ones_q <= '0;
                                fcnt_q <= '0;
                            end else begin
                                st_q <= ST_PHY;
                            end
                        end
                    end
                    ST_PHY: begin
                        if (fld_end) begin
                            hdr_q.hit <= (sh_nx[PHY_AW-1:0] == my_addr);
                            st_q      <= ST_REG;
                        end
                    end
                    ST_REG: begin
                        if (fld_end) begin
                            hdr_q.regad <= sh_nx[REG_AW-1:0];
                            st_q        <= ST_TA;
                        end
                    end
                    ST_TA: begin
                        if ((hdr_q.kind == XACT_WR) && (bit_s != ta_exp)) begin
                            st_q   <= ST_HUNT;
                            ones_q <= '0;
                            fcnt_q <= '0;
                        end else if (fld_end) begin
                            st_q <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (fld_end) begin
                            st_q   <= ST_HUNT;
                            ones_q <= '0;
                            if ((hdr_q.kind == XACT_WR) && hdr_q.hit) begin
                                wr_en_q   <= 1'b1;
                                wr_data_q <= sh_nx;
                            end
                        end
                    end
                    default: begin
                        st_q   <= ST_HUNT;
                        ones_q <= '0;
                        fcnt_q <= '0;
                    end
                endcase
            end
        end
    end

    // output value for the bit time that begins at this falling edge
    always_comb begin
        drv_d = '{oe: 1'b0, dat: 1'b0};
        if (rd_hit && (st_q == ST_TA) && (fcnt_q == FLD_CW'(1)))
            drv_d = '{oe: 1'b1, dat: 1'b0};
        else if (rd_hit && (st_q == ST_DATA))
            drv_d = '{oe: 1'b1, dat: rd_word[TOP_IDX - fcnt_q]};
    end

    always_ff @(posedge clk) begin
        if (rst)           drv_q <= '{oe: 1'b0, dat: 1'b0};
        else if (fall_evt) drv_q <= drv_d;
    end

    assign wr_en    = wr_en_q;
    assign wr_data  = wr_data_q;
    assign reg_addr = hdr_q.regad;
    assign mdio_out = drv_q.dat;
    assign mdio_oe  = drv_q.oe;

    // R4: pin outputs move only right after a detected clock fall
    assert_drv_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (drv_q != $past(drv_q)) |-> $past(fall_evt));

    // R5: the line is taken only for a read aimed at this device
    assert_drive_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> rd_hit);

    // R3: the driven turnaround bit is zero
    assert_ta_low_R3: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && (st_q == ST_TA)) |-> !mdio_out);

    // R6: a start field is accepted only after a full preamble
    assert_start_after_preamble_R6: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) == ST_HUNT) && (st_q == ST_START)) |-> ($past(ones_q) == PRE_CW'(PRE_LEN)));

endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PHY_AW-1:0] phy_addr_cfg,
    input  logic              mdc_in,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic              rise_evt;
    logic              fall_evt;
    logic              bit_s;
    logic              wr_en;
    logic [REG_AW-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_word;

    mdio_pin_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_in   (mdc_in),
        .mdio_in  (mdio_in),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .bit_s    (bit_s)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .bit_s    (bit_s),
        .my_addr  (phy_addr_cfg),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_bank #(.AW(REG_AW), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (reg_addr),
        .wr_data (wr_data),
        .rd_data (rd_word)
    );

endmodule

// File: tb/mdio_target_tb.sv
module mdio_target_tb;
    localparam int         HALF      = 8;
    localparam logic [4:0] MY_PHY    = 5'h0B;
    localparam logic [4:0] OTHER_PHY = 5'h0C;

    typedef struct packed {
        logic [4:0]  ra;
        logic [15:0] val;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{ra: 5'd0,  val: 16'hA5C3},
        '{ra: 5'd31, val: 16'h5A3C},
        '{ra: 5'd7,  val: 16'hFFFF},
        '{ra: 5'd18, val: 16'h8001},
        '{ra: 5'd12, val: 16'h7FFE},
        '{ra: 5'd3,  val: 16'h1234}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mdc = 1'b0;
    logic ctl_en = 1'b0;
    logic ctl_bit = 1'b1;
    logic mdio_out;
    logic mdio_oe;
    logic bus;

    assign bus = mdio_oe ? mdio_out : (ctl_en ? ctl_bit : 1'b1);

    always #4 clk = ~clk;

    mdio_target u_dut (
        .clk          (clk),
        .rst          (rst),
        .phy_addr_cfg (MY_PHY),
        .mdc_in       (mdc),
        .mdio_in      (bus),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int fall_cyc = 0;
    int late = 0;
    int clash = 0;
    int oe_cnt = 0;
    logic done = 1'b0;
    logic [1:0] drv_prev = 2'b00;
    logic [15:0] model [32];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if ({mdio_oe, mdio_out} != drv_prev && (cyc - fall_cyc) > 4) late++;
            drv_prev = {mdio_oe, mdio_out};
            if (mdio_oe) oe_cnt++;
            if (mdio_oe && ctl_en) clash++;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, input logic rel, output logic seen);
        @(negedge clk);
        mdc = 1'b0;
        fall_cyc = cyc;
        ctl_en = !rel;
        ctl_bit = b;
        repeat (HALF) @(negedge clk);
        mdc = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        seen = bus;
        repeat (HALF - HALF / 2) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] ta,
                         input logic [15:0] d, output logic [17:0] got, output int oe_seen);
        int   oe0 = oe_cnt;
        logic s;
        logic rd = (op == 2'b10);
        for (int i = 0; i < pre; i++) put_bit(1'b1, 1'b0, s);
        put_bit(st[1], 1'b0, s);
        put_bit(st[0], 1'b0, s);
        put_bit(op[1], 1'b0, s);
        put_bit(op[0], 1'b0, s);
        for (int i = 4; i >= 0; i--) put_bit(phy[i], 1'b0, s);
        for (int i = 4; i >= 0; i--) put_bit(ra[i], 1'b0, s);
        for (int i = 17; i >= 0; i--) begin
            logic v = (i == 17) ? ta[1] : (i == 16) ? ta[0] : d[i];
            put_bit(v, rd, s);
            got[i] = s;
        end
        @(negedge clk);
        mdc = 1'b0;
        fall_cyc = cyc;
        ctl_en = 1'b0;
        repeat (HALF) @(negedge clk);
        oe_seen = oe_cnt - oe0;
    endtask

    task automatic wr(input int pre, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        logic [17:0] g;
        int o;
        frame(pre, 2'b01, 2'b01, phy, ra, 2'b10, d, g, o);
        chk("R3 no drive in write frame", o, 0);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] ra, input logic [15:0] exp);
        logic [17:0] g;
        int o;
        frame(32, 2'b01, 2'b10, MY_PHY, ra, 2'b11, 16'h0, g, o);
        chk({tag, " R3 TA1 undriven"}, g[17], 1'b1);
        chk({tag, " R3 TA2 zero"}, g[16], 1'b0);
        chk({tag, " data"}, g[15:0], exp);
        chk({tag, " R3 released"}, mdio_oe, 1'b0);
    endtask

    initial begin
        logic [17:0] g;
        int o;
        for (int i = 0; i < 32; i++) model[i] = 16'h0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe low after reset", mdio_oe, 1'b0);
        rd_chk("R1 reset value", 5'd5, 16'h0);

        // table: store every vector, then read all back
        for (int i = 0; i < 6; i++) begin
            wr(32, MY_PHY, VECS[i].ra, VECS[i].val);
            model[VECS[i].ra] = VECS[i].val;
        end
        for (int i = 0; i < 6; i++) rd_chk("R2 R10 table read", VECS[i].ra, model[VECS[i].ra]);

        // R5 foreign address
        wr(32, OTHER_PHY, 5'd3, 16'hDEAD);
        frame(32, 2'b01, 2'b10, OTHER_PHY, 5'd3, 2'b11, 16'h0, g, o);
        chk("R5 no drive for foreign read", o, 0);
        chk("R5 line idle for foreign read", g, 18'h3FFFF);
        rd_chk("R5 foreign write dropped", 5'd3, model[3]);

        // R6 short preamble (the previous frame completed, count is clear)
        wr(31, MY_PHY, 5'd9, 16'h4321);
        rd_chk("R6 short write dropped", 5'd9, model[9]);
        frame(31, 2'b01, 2'b10, MY_PHY, 5'd0, 2'b11, 16'h0, g, o);
        chk("R6 short read undriven", o, 0);

        // R7 bad start field, then recovery
        frame(32, 2'b00, 2'b01, MY_PHY, 5'd10, 2'b10, 16'h0F0F, g, o);
        rd_chk("R7 bad start dropped", 5'd10, model[10]);
        wr(32, MY_PHY, 5'd10, 16'h0F0F);
        model[10] = 16'h0F0F;
        rd_chk("R7 recovery", 5'd10, model[10]);

        // R8 bad write turnaround
        frame(32, 2'b01, 2'b01, MY_PHY, 5'd11, 2'b11, 16'h2468, g, o);
        rd_chk("R8 bad TA dropped", 5'd11, model[11]);

        // R9 invalid opcodes
        frame(32, 2'b01, 2'b11, MY_PHY, 5'd0, 2'b10, 16'h0000, g, o);
        chk("R9 opcode 11 undriven", o, 0);
        frame(32, 2'b01, 2'b00, MY_PHY, 5'd0, 2'b10, 16'h1357, g, o);
        chk("R9 opcode 00 undriven", o, 0);
        rd_chk("R9 opcode 00 no store", 5'd0, model[0]);

        // R11 long preamble
        wr(40, MY_PHY, 5'd20, 16'hC0DE);
        model[20] = 16'hC0DE;
        rd_chk("R11 long preamble", 5'd20, model[20]);

        // R10 boundary rows intact after all traffic
        rd_chk("R10 row 31", 5'd31, model[31]);
        rd_chk("R10 row 0", 5'd0, model[0]);

        chk("R4 drive changes follow clock fall", late, 0);
        chk("R3 no contention", clash, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule